// File: doc/BRIEF.md
# Coprocessor Branch Resolution Unit

This block decides, for one branch instruction of a small sequencing coprocessor, whether the branch is taken and which word address executes next. The decode stage hands it the current program counter, the branch family, a condition code and the instruction fields. The execution side supplies the values the conditions need: general register R0, the register chosen as a jump target, the stage counter, and the zero and overflow flags left by the previous ALU operation.

Three families are handled. The first is absolute jumps, gated by the ALU flags, that go to an immediate or a register-held address. The second is relative branches that compare R0 with a 16-bit immediate. The third is relative branches that compare the stage counter with an 8-bit immediate. A relative displacement is a 7-bit magnitude with a separate direction bit. The result is registered: a request presented on one clock edge produces its taken bit and next PC after that edge. When a branch is not taken, the next PC is the following word.

Top module: `brx_unit`

## Requirements
- R1: `res_valid` is high in the cycle after an edge where `req_valid` was high, and low in the cycle after an edge where it was low. `res_taken` and `res_next_pc` belong to the most recent captured request.
- R2: A request that is not taken yields `res_taken`=0 and `res_next_pc` = `pc`+1 modulo 2^PC_W, so address 2047 is followed by 0.
- R3: Family 0 (absolute) jumps to the low PC_W bits of `treg_val` when `tgt_from_reg`=1, and to `imm_addr` when it is 0.
- R4: For family 0, `cond_code` 0 is always taken, 1 is taken when `flag_zero`=1, 2 is taken when `flag_ovf`=1, and 3 is never taken.
- R5: For family 1 (R0 compare), `cond_code` 0 is taken when `r0_val` < `cmp_imm` and 1 is taken when `r0_val` >= `cmp_imm`, both unsigned. Codes 2 and 3 are never taken.
- R6: For family 2 (stage compare), the stage counter is compared unsigned with `cmp_imm[7:0]`; `cmp_imm[15:8]` is ignored. `cond_code` 0 is taken on less than, 1 on greater or equal, 2 on less or equal, and 3 is never taken.
- R7: A taken branch in family 1 or 2 goes to `pc`+`off_mag` when `off_back`=0 and to `pc`-`off_mag` when `off_back`=1, modulo 2^PC_W.
- R8: Family 3 is never taken.
- R9: During and after reset, `res_valid`, `res_taken` and `res_next_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch is presented this cycle |
| pc | input | 11 | Word address of the branch |
| family | input | 2 | 0 absolute, 1 R0 compare, 2 stage compare, 3 none |
| cond_code | input | 2 | Condition code within the family |
| tgt_from_reg | input | 1 | Absolute target from register (1) or immediate (0) |
| off_back | input | 1 | Relative direction: 0 forward, 1 backward |
| off_mag | input | 7 | Relative displacement magnitude in words |
| imm_addr | input | 11 | Immediate absolute target |
| cmp_imm | input | 16 | Comparison immediate |
| r0_val | input | 16 | Value of R0 |
| treg_val | input | 16 | Value of the target register |
| stage_cnt | input | 8 | Stage counter |
| flag_zero | input | 1 | Last ALU result was zero |
| flag_ovf | input | 1 | Last ALU operation overflowed |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 11 | Next program counter |

## Verification
The bench builds the block with its default widths: an 11-bit PC, 16-bit data, an 8-bit stage counter and a 7-bit magnitude. At these widths the 2048-word wrap is reached from both ends by a 127-word displacement. The register target exercises truncation of a 16-bit value to 11 bits. The stage compare can be fed a 16-bit immediate whose upper byte must not count. Equality and off-by-one operands exercise every comparison boundary in both compare families.

// File: rtl/brx_pkg.sv
package brx_pkg;

    localparam int unsigned PC_W_DEF   = 11;
    localparam int unsigned DATA_W_DEF = 16;
    localparam int unsigned STG_W_DEF  = 8;
    localparam int unsigned OFF_W_DEF  = 7;

    typedef enum logic [1:0] {
        FAM_ABS  = 2'd0,
        FAM_R0   = 2'd1,
        FAM_STG  = 2'd2,
        FAM_NONE = 2'd3
    } fam_e;

    localparam logic [1:0] CC_ALWAYS = 2'd0;
    localparam logic [1:0] CC_ZERO   = 2'd1;
    localparam logic [1:0] CC_OVF    = 2'd2;

    localparam logic [1:0] CC_LT = 2'd0;
    localparam logic [1:0] CC_GE = 2'd1;
    localparam logic [1:0] CC_LE = 2'd2;

    function automatic logic rel_hit(input logic [1:0] cc, input logic lt,
                                     input logic eq, input logic le_ok);
        case (cc)
            CC_LT:   rel_hit = lt;
            CC_GE:   rel_hit = !lt;
            CC_LE:   rel_hit = le_ok && (lt || eq);
            default: rel_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned STG_W  = STG_W_DEF
) (
    input  fam_e              fam,
    input  logic [1:0]        cc,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] r0,
    input  logic [STG_W-1:0]  stage,
    input  logic              zf,
    input  logic              of,
    output logic              hit
);
    logic r0_lt, r0_eq, st_lt, st_eq, abs_hit;

    assign r0_lt = r0 < imm;
    assign r0_eq = r0 == imm;
    assign st_lt = stage < imm[STG_W-1:0];
    assign st_eq = stage == imm[STG_W-1:0];

    always_comb begin
        case (cc)
            CC_ALWAYS: abs_hit = 1'b1;
            CC_ZERO:   abs_hit = zf;
            CC_OVF:    abs_hit = of;
            default:   abs_hit = 1'b0;
        endcase
    end

    always_comb begin
        case (fam)
            FAM_ABS: hit = abs_hit;
            FAM_R0:  hit = rel_hit(cc, r0_lt, r0_eq, 1'b0);
            FAM_STG: hit = rel_hit(cc, st_lt, st_eq, 1'b1);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int unsigned PC_W   = PC_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned OFF_W  = OFF_W_DEF
) (
    input  fam_e              fam,
    input  logic [PC_W-1:0]   pc,
    input  logic              from_reg,
    input  logic              back,
    input  logic [OFF_W-1:0]  mag,
    input  logic [PC_W-1:0]   imm_addr,
    input  logic [DATA_W-1:0] treg,
    output logic [PC_W-1:0]   tgt
);
    localparam int unsigned PAD_W = PC_W - OFF_W;

    logic [PC_W-1:0] mag_x, fwd, bwd, abs_t;
    logic unused_treg_hi;

    assign unused_treg_hi = ^treg[DATA_W-1:PC_W];
    assign mag_x = {{PAD_W{1'b0}}, mag};
    assign fwd   = pc + mag_x;
    assign bwd   = pc - mag_x;
    assign abs_t = from_reg ? treg[PC_W-1:0] : imm_addr;
    assign tgt   = (fam == FAM_ABS) ? abs_t : (back ? bwd : fwd);
endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter int unsigned PC_W   = PC_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned STG_W  = STG_W_DEF,
    parameter int unsigned OFF_W  = OFF_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   pc,
    input  logic [1:0]        family,
    input  logic [1:0]        cond_code,
    input  logic              tgt_from_reg,
    input  logic              off_back,
    input  logic [OFF_W-1:0]  off_mag,
    input  logic [PC_W-1:0]   imm_addr,
    input  logic [DATA_W-1:0] cmp_imm,
    input  logic [DATA_W-1:0] r0_val,
    input  logic [DATA_W-1:0] treg_val,
    input  logic [STG_W-1:0]  stage_cnt,
    input  logic              flag_zero,
    input  logic              flag_ovf,
    output logic              res_valid,
    output logic              res_taken,
    output logic [PC_W-1:0]   res_next_pc
);
    fam_e            fam;
    logic            hit;
    logic [PC_W-1:0] tgt, seq_pc, nxt;

    assign fam = fam_e'(family);

    brx_cond #(.DATA_W(DATA_W), .STG_W(STG_W)) u_cond (
        .fam   (fam),
        .cc    (cond_code),
        .imm   (cmp_imm),
        .r0    (r0_val),
        .stage (stage_cnt),
        .zf    (flag_zero),
        .of    (flag_ovf),
        .hit   (hit)
    );

    brx_target #(.PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_tgt (
        .fam      (fam),
        .pc       (pc),
        .from_reg (tgt_from_reg),
        .back     (off_back),
        .mag      (off_mag),
        .imm_addr (imm_addr),
        .treg     (treg_val),
        .tgt      (tgt)
    );

    assign seq_pc = pc + {{(PC_W-1){1'b0}}, 1'b1};
    assign nxt    = hit ? tgt : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_taken   <= hit;
                res_next_pc <= nxt;
            end
        end
    end
endmodule

// File: rtl/brx_chk.sv
module brx_chk #(
    parameter int unsigned PC_W   = 11,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STG_W  = 8,
    parameter int unsigned OFF_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [PC_W-1:0]   pc,
    input logic [1:0]        family,
    input logic [1:0]        cond_code,
    input logic              tgt_from_reg,
    input logic              off_back,
    input logic [OFF_W-1:0]  off_mag,
    input logic [PC_W-1:0]   imm_addr,
    input logic [DATA_W-1:0] cmp_imm,
    input logic [STG_W-1:0]  stage_cnt,
    input logic [DATA_W-1:0] treg_val,
    input logic              res_valid,
    input logic              res_taken,
    input logic [PC_W-1:0]   res_next_pc
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (res_taken || res_next_pc == $past(pc) + PC_W'(1)));

    a_r3_abs_target: assert property (@(posedge clk) disable iff (rst)
        (req_valid && family == 2'd0) |=> (!res_taken || res_next_pc ==
            ($past(tgt_from_reg) ? $past(treg_val[PC_W-1:0]) : $past(imm_addr))));

    a_r4_always: assert property (@(posedge clk) disable iff (rst)
        (req_valid && family == 2'd0 && cond_code == 2'd0) |=> res_taken);

    a_r6_le_on_equal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && family == 2'd2 && cond_code == 2'd2
         && stage_cnt == cmp_imm[STG_W-1:0]) |=> res_taken);

    a_r7_forward: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (family == 2'd1 || family == 2'd2) && !off_back) |=>
        (!res_taken || res_next_pc == $past(pc) + PC_W'($past(off_mag))));

    a_r8_none: assert property (@(posedge clk) disable iff (rst)
        (req_valid && family == 2'd3) |=> !res_taken);

    a_r9_reset: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_taken && res_next_pc == '0));
endmodule

bind brx_unit brx_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .STG_W(STG_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pc(pc), .family(family),
    .cond_code(cond_code), .tgt_from_reg(tgt_from_reg), .off_back(off_back),
    .off_mag(off_mag), .imm_addr(imm_addr), .cmp_imm(cmp_imm), .stage_cnt(stage_cnt),
    .treg_val(treg_val), .res_valid(res_valid), .res_taken(res_taken),
    .res_next_pc(res_next_pc)
);

// File: tb/sim_brx_unit.sv
`timescale 1ns/1ps
module sim_brx_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [10:0] pc = '0;
    logic [1:0]  family = '0;
    logic [1:0]  cond_code = '0;
    logic        tgt_from_reg = 1'b0;
    logic        off_back = 1'b0;
    logic [6:0]  off_mag = '0;
    logic [10:0] imm_addr = '0;
    logic [15:0] cmp_imm = '0;
    logic [15:0] r0_val = '0;
    logic [15:0] treg_val = '0;
    logic [7:0]  stage_cnt = '0;
    logic        flag_zero = 1'b0;
    logic        flag_ovf = 1'b0;
    logic        res_valid, res_taken;
    logic [10:0] res_next_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brx_unit u0 (.*);

    function automatic bit exp_taken();
        case (family)
            2'd0: return cond_code == 2'd0 || (cond_code == 2'd1 && flag_zero)
                         || (cond_code == 2'd2 && flag_ovf);
            2'd1: return (cond_code == 2'd0 && r0_val < cmp_imm)
                         || (cond_code == 2'd1 && r0_val >= cmp_imm);
            2'd2: return (cond_code == 2'd0 && stage_cnt < cmp_imm[7:0])
                         || (cond_code == 2'd1 && stage_cnt >= cmp_imm[7:0])
                         || (cond_code == 2'd2 && stage_cnt <= cmp_imm[7:0]);
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_pc();
        int p = int'(pc);
        if (!exp_taken()) return (p + 1) % 2048;
        if (family == 2'd0) return tgt_from_reg ? int'(treg_val) % 2048 : int'(imm_addr);
        if (off_back) return (p - int'(off_mag) + 2048) % 2048;
        return (p + int'(off_mag)) % 2048;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input string req);
        bit et;
        int ep;
        et = exp_taken();
        ep = exp_pc();
        req_valid = 1'b1;
        @(negedge clk);
        check(req, int'(res_valid), 1);
        check(req, int'(res_taken), int'(et));
        check(req, int'(res_next_pc), ep);
        req_valid = 1'b0;
    endtask

    task automatic setf(input logic [1:0] f, input logic [1:0] c, input logic [10:0] p);
        family = f; cond_code = c; pc = p;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R9", int'(res_valid), 0);
        check("R9", int'(res_taken), 0);
        check("R9", int'(res_next_pc), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(res_valid), 0);

        setf(2'd3, 2'd0, 11'd2047); run("R2");
        setf(2'd0, 2'd0, 11'd5); tgt_from_reg = 1'b1; treg_val = 16'hFFFF; run("R3");
        tgt_from_reg = 1'b0; imm_addr = 11'd1234; run("R3");
        setf(2'd0, 2'd1, 11'd9); flag_zero = 1'b0; run("R4");
        flag_zero = 1'b1; run("R4");
        setf(2'd0, 2'd2, 11'd9); flag_ovf = 1'b1; run("R4");
        setf(2'd0, 2'd3, 11'd9); flag_zero = 1'b1; run("R4");
        setf(2'd1, 2'd0, 11'd3); r0_val = 16'd500; cmp_imm = 16'd500;
        off_back = 1'b1; off_mag = 7'd10; run("R5");
        setf(2'd1, 2'd1, 11'd3); run("R7");
        setf(2'd1, 2'd2, 11'd3); run("R5");
        setf(2'd2, 2'd0, 11'd2040); off_back = 1'b0; off_mag = 7'd127;
        stage_cnt = 8'd7; cmp_imm = 16'hFF08; run("R7");
        setf(2'd2, 2'd1, 11'd100); cmp_imm = 16'h0107; run("R6");
        setf(2'd2, 2'd2, 11'd100); cmp_imm = 16'h8007; run("R6");
        setf(2'd2, 2'd2, 11'd100); cmp_imm = 16'h0006; run("R6");
        setf(2'd2, 2'd3, 11'd100); run("R6");
        setf(2'd3, 2'd0, 11'd50); run("R8");
        @(negedge clk);
        check("R1", int'(res_valid), 0);
        check("R1", int'(res_next_pc), 51);

        for (int i = 0; i < 3000; i++) begin
            family = 2'($urandom); cond_code = 2'($urandom); pc = 11'($urandom);
            tgt_from_reg = 1'($urandom); off_back = 1'($urandom);
            off_mag = 7'($urandom); imm_addr = 11'($urandom);
            cmp_imm = 16'($urandom); r0_val = 16'($urandom);
            if ($urandom % 4 == 0) r0_val = cmp_imm + 16'($urandom % 3) - 16'd1;
            stage_cnt = 8'($urandom);
            if ($urandom % 4 == 0) stage_cnt = cmp_imm[7:0] + 8'($urandom % 3) - 8'd1;
            treg_val = 16'($urandom); flag_zero = 1'($urandom); flag_ovf = 1'($urandom);
            case (family)
                2'd0: run("R4");
                2'd1: run("R5");
                2'd2: run("R6");
                default: run("R8");
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule